// File: doc/BRIEF.md
# TU-12 channel column locator

This block sits on a byte-wide parallel bus that carries the payload of an STM-1 frame, one byte per clock, with a column number and a payload-area marker beside each byte. A channel select picks one of the 63 TU-12 tributaries. The block finds the four interleaved payload columns that belong to that tributary, counts the tributary's bytes around its 144-byte multiframe and discards the four pointer bytes. It passes every other byte of the tributary out with a one-cycle valid strobe.

The block keeps the two low bits of the first pointer byte and all of the second pointer byte. Together they form a 10-bit offset to the tributary's path overhead byte. The block converts that offset into a byte position inside the multiframe, stepping over the pointer bytes. When the tributary byte at that position goes by, it raises a super-frame-start pulse alongside the data strobe. A strobe from upstream marks the first pointer byte and restarts the count.

Top module: `tu12_locator`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `data_vld`, `sf_start` and `data_out` are all 0.
- R2: For a channel k in 1..63, let j = k-1 and base = 9 + 21*(j mod 3) + 3*((j div 3) mod 7) + (j div 21). A bus byte is a channel byte only when `pay_area` is 1 and `col_num` equals base, base+63, base+126 or base+189 (9-bit arithmetic).
- R3: One cycle after a channel byte that is not a pointer byte, `data_vld` is 1 and `data_out` holds that byte. In every other cycle `data_vld` is 0 and `data_out` keeps its value.
- R4: Channel bytes take positions 0 to 143 in turn and wrap after 143. Positions 0, 36, 72 and 108 are pointer bytes and never raise `data_vld`. Bus bytes that are not channel bytes do not advance the position.
- R5: The offset is {byte at position 0 [1:0], byte at position 36 [7:0]} as a 10-bit value. It becomes usable once a position-36 byte has been seen since reset.
- R6: The offset maps to a target position: 0..34 map to offset+37, 35..69 to offset+38, 70..104 to offset+39 and 105..139 to offset-104. `sf_start` is 1 in the same cycle as the `data_vld` of the channel byte at the target position.
- R7: If the offset is above 139, or no position-36 byte has been seen since reset, `sf_start` stays 0.
- R8: With `chan_sel` = 0, no byte is a channel byte. `data_vld` and `sf_start` stay 0 and the position does not move.
- R9: When `v1_seen` is 1 together with a channel byte, that byte takes position 0 whatever the previous count was. When `v1_seen` is 1 without a channel byte, the next channel byte takes position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Payload byte on the bus |
| pay_area | input | 1 | High while the bus byte lies in the payload area |
| col_num | input | 9 | Payload column number of the bus byte |
| v1_seen | input | 1 | Marks the first pointer byte of the tributary |
| chan_sel | input | 6 | Selected tributary, 1..63; 0 disables the block |
| data_vld | output | 1 | Registered strobe for a tributary data byte |
| data_out | output | 8 | Registered copy of the last tributary data byte |
| sf_start | output | 1 | Registered pulse on the path overhead byte |

## Verification
A wrong column decode shows up within one bus row of 261 bytes. The strobe then lands on a foreign column, or on no column at all. A position counter that slips or wraps at the wrong count moves the gaps left by the pointer bytes, and the strobe count over a multiframe drifts from 140 per 144 bytes by the next pointer position. A wrong offset capture or mapping moves or removes the super-frame pulse. This is visible at most one multiframe after the second pointer byte, and it is checked at the range edges 34/35, 69/70, 104/105 and 139/140, and with high bits in the first pointer byte.

// File: rtl/tu12_pkg.sv
package tu12_pkg;
  // Structure of the interleaved payload: 3 groups of 7 sub-groups of 3 tributaries.
  localparam int FIRST_COL = 9;
  localparam int GRP_N     = 3;
  localparam int SUB_N     = 7;
  localparam int TRIB_N    = 3;

  // First payload column of tributary ch (1-based); ch 0 returns the column of ch 1.
  function automatic int first_col(input int ch);
    int j;
    j = (ch > 0) ? ch - 1 : 0;
    return FIRST_COL + (SUB_N * TRIB_N) * (j % GRP_N)
         + TRIB_N * ((j / GRP_N) % SUB_N)
         + j / (GRP_N * SUB_N);
  endfunction
endpackage

// File: rtl/tu12_col_match.sv
module tu12_col_match #(
  parameter int COL_W = 9,
  parameter int SEL_W = 6,
  parameter int N_CH  = 63,
  parameter int N_REP = 4
) (
  input  logic [COL_W-1:0] col_num,
  input  logic             pay_area,
  input  logic [SEL_W-1:0] chan_sel,
  output logic             hit
);
  logic [N_REP-1:0] m;
  logic             sel_ok;
  int               base;

  always_comb begin
    base   = tu12_pkg::first_col(int'(chan_sel));
    sel_ok = (chan_sel != '0) && (int'(chan_sel) <= N_CH);
  end

  for (genvar g = 0; g < N_REP; g++) begin : g_rep
    assign m[g] = (col_num == COL_W'(base + g * N_CH));
  end

  assign hit = sel_ok && pay_area && (|m);
endmodule

// File: rtl/tu12_pos_counter.sv
module tu12_pos_counter #(
  parameter int DATA_W   = 8,
  parameter int TU_BYTES = 144,
  parameter int OFF_W    = 10,
  localparam int POS_W   = $clog2(TU_BYTES),
  localparam int QTR     = TU_BYTES / 4,
  localparam int HI_W    = OFF_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              v1_seen,
  input  logic [DATA_W-1:0] bus_data,
  output logic [POS_W-1:0]  pos,
  output logic              is_ptr,
  output logic [OFF_W-1:0]  off,
  output logic              off_valid
);
  logic [POS_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_q;

  assign pos = v1_seen ? '0 : cnt_q;

  always_comb begin
    is_ptr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (pos == POS_W'(k * QTR)) is_ptr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      hi_q      <= '0;
      off       <= '0;
      off_valid <= 1'b0;
    end else if (hit) begin
      cnt_q <= (pos == POS_W'(TU_BYTES - 1)) ? '0 : pos + 1'b1;
      if (pos == '0) hi_q <= bus_data[HI_W-1:0];
      if (pos == POS_W'(QTR)) begin
        off       <= {hi_q, bus_data};
        off_valid <= 1'b1;
      end
    end else if (v1_seen) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/tu12_v5_map.sv
module tu12_v5_map #(
  parameter int TU_BYTES = 144,
  parameter int OFF_W    = 10,
  localparam int POS_W   = $clog2(TU_BYTES),
  localparam int QTR     = TU_BYTES / 4,
  localparam int SEG     = QTR - 1
) (
  input  logic [OFF_W-1:0] off,
  output logic [POS_W-1:0] addr,
  output logic             ok
);
  always_comb begin
    int o;
    o    = int'(off);
    ok   = 1'b0;
    addr = '0;
    for (int k = 0; k < 4; k++) begin
      if (o >= k * SEG && o < (k + 1) * SEG) begin
        ok   = 1'b1;
        addr = POS_W'(o - k * SEG + ((k + 1) % 4) * QTR + 1);
      end
    end
  end
endmodule

// File: rtl/tu12_locator.sv
module tu12_locator #(
  parameter int DATA_W   = 8,
  parameter int COL_W    = 9,
  parameter int SEL_W    = 6,
  parameter int N_CH     = 63,
  parameter int TU_BYTES = 144,
  parameter int OFF_W    = 10,
  localparam int POS_W   = $clog2(TU_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              pay_area,
  input  logic [COL_W-1:0]  col_num,
  input  logic              v1_seen,
  input  logic [SEL_W-1:0]  chan_sel,
  output logic              data_vld,
  output logic [DATA_W-1:0] data_out,
  output logic              sf_start
);
  logic             hit;
  logic [POS_W-1:0] pos;
  logic             is_ptr;
  logic [OFF_W-1:0] off;
  logic             off_valid;
  logic [POS_W-1:0] addr;
  logic             off_ok;

  tu12_col_match #(.COL_W(COL_W), .SEL_W(SEL_W), .N_CH(N_CH), .N_REP(4)) u_match (
    .col_num (col_num),
    .pay_area(pay_area),
    .chan_sel(chan_sel),
    .hit     (hit)
  );

  tu12_pos_counter #(.DATA_W(DATA_W), .TU_BYTES(TU_BYTES), .OFF_W(OFF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .v1_seen  (v1_seen),
    .bus_data (bus_data),
    .pos      (pos),
    .is_ptr   (is_ptr),
    .off      (off),
    .off_valid(off_valid)
  );

  tu12_v5_map #(.TU_BYTES(TU_BYTES), .OFF_W(OFF_W)) u_map (
    .off (off),
    .addr(addr),
    .ok  (off_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_vld <= 1'b0;
      data_out <= '0;
      sf_start <= 1'b0;
    end else begin
      data_vld <= hit && !is_ptr;
      sf_start <= hit && off_valid && off_ok && (pos == addr);
      if (hit && !is_ptr) data_out <= bus_data;
    end
  end
endmodule

// File: rtl/tu12_locator_chk.sv
module tu12_locator_chk #(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 6,
  parameter int TU_BYTES = 144,
  localparam int POS_W   = $clog2(TU_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              pay_area,
  input logic [SEL_W-1:0]  chan_sel,
  input logic              data_vld,
  input logic [DATA_W-1:0] data_out,
  input logic              sf_start,
  input logic [POS_W-1:0]  pos,
  input logic              off_ok,
  input logic              off_valid
);
  AST_PAY_NEEDED: assert property (@(posedge clk) disable iff (rst)
    data_vld |-> $past(pay_area)); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_vld |-> $stable(data_out)); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < TU_BYTES); // R4
  AST_SF_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> data_vld); // R6
  AST_SF_NEEDS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> $past(off_valid && off_ok)); // R7
  AST_SEL0_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(chan_sel) == '0) |-> (!data_vld && !sf_start)); // R8
endmodule

bind tu12_locator tu12_locator_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .TU_BYTES(TU_BYTES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pay_area (pay_area),
  .chan_sel (chan_sel),
  .data_vld (data_vld),
  .data_out (data_out),
  .sf_start (sf_start),
  .pos      (pos),
  .off_ok   (off_ok),
  .off_valid(off_valid)
);

// File: tb/tu12_locator_tb.sv
module tu12_locator_tb;
  localparam int ROW  = 261;
  localparam int NCYC = ROW * 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = '0;
  logic       pay_area = 1'b0;
  logic [8:0] col_num = '0;
  logic       v1_seen = 1'b0;
  logic [5:0] chan_sel = '0;
  logic       data_vld;
  logic [7:0] data_out;
  logic       sf_start;

  always #4 clk = ~clk;

  tu12_locator u_dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .pay_area(pay_area),
    .col_num(col_num), .v1_seen(v1_seen), .chan_sel(chan_sel),
    .data_vld(data_vld), .data_out(data_out), .sf_start(sf_start)
  );

  int n_chk = 0, n_fail = 0;
  int tab[64];
  // reference model state
  int m_cnt, m_hi, m_off, m_offv;
  logic p_vld, p_sf; logic [7:0] p_data;
  int d_vld_n, d_sf_n, m_vld_n, m_sf_n;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int target(input int o);
    if (o < 35) return o + 37;
    if (o < 70) return o + 38;
    if (o < 105) return o + 39;
    if (o < 140) return o - 104;
    return -1;
  endfunction

  function automatic bit is_hit(input int ch, input bit pay, input int col);
    if (ch == 0 || !pay) return 0;
    return col == tab[ch] || col == tab[ch] + 63 || col == tab[ch] + 126 || col == tab[ch] + 189;
  endfunction

  task automatic compare();
    check("R3 data_vld", data_vld, p_vld);
    check("R3 data_out", data_out, p_data);
    check("R6 sf_start", sf_start, p_sf);
    d_vld_n += data_vld; d_sf_n += sf_start;
  endtask

  task automatic do_reset();
    rst = 1'b1; chan_sel = 6'd7; pay_area = 1'b1; col_num = 9'd9; bus_data = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1 reset data_vld", data_vld, 0);
    check("R1 reset sf_start", sf_start, 0);
    check("R1 reset data_out", data_out, 0);
    rst = 1'b0;
    m_cnt = 0; m_hi = 0; m_off = 0; m_offv = 0;
    p_vld = 0; p_sf = 0; p_data = '0;
    d_vld_n = 0; d_sf_n = 0; m_vld_n = 0; m_sf_n = 0;
  endtask

  task automatic run(input int ch, input int v1b, input int v2b, input bit drop, input bit resync);
    int bidx, bpos;
    bidx = 0; bpos = 0;
    do_reset();
    chan_sel = 6'(ch);
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit h, v;
      int pos;
      logic [7:0] d;
      compare();
      col_num  = 9'(cyc % ROW);
      pay_area = !(drop && ((cyc / ROW) % 5 == 2));
      h = is_hit(ch, pay_area, cyc % ROW);
      v = h && ((bidx % 144 == 0) || (resync && bidx == 50));
      if (v) bpos = 0;
      d = 8'($urandom);
      if (h && bpos == 0) d = {d[7:2], 2'(v1b)};
      if (h && bpos == 36) d = 8'(v2b);
      if (h) begin bidx++; bpos = (bpos + 1) % 144; end
      v1_seen = v; bus_data = d;
      // behavioural model
      pos = v ? 0 : m_cnt;
      p_vld = h && !(pos == 0 || pos == 36 || pos == 72 || pos == 108);
      p_sf  = h && m_offv != 0 && target(m_off) == pos;
      if (p_vld) p_data = d;
      if (h) begin
        if (pos == 0) m_hi = d[1:0];
        if (pos == 36) begin m_off = m_hi * 256 + d; m_offv = 1; end
        m_cnt = (pos + 1) % 144;
      end else if (v) m_cnt = 0;
      m_vld_n += p_vld; m_sf_n += p_sf;
      @(negedge clk);
    end
    compare();
    v1_seen = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 7; b++)
          tab[1 + a + 3 * b + 21 * c] = 9 + 21 * a + 3 * b + c;
    tab[0] = 0;
  end

  initial begin
    @(negedge clk);
    run(1, 0, 0, 0, 0);
    check("R6 sf count off 0", d_sf_n, 2);
    check("R4 valid bytes in 200", d_vld_n, 194);
    run(63, 0, 34, 0, 0);
    check("R6 sf count off 34", d_sf_n, 1);
    check("R2 valid bytes chan 63", d_vld_n, 194);
    run(22, 0, 35, 0, 0);
    check("R6 sf count off 35", d_sf_n, 1);
    run(40, 0, 104, 0, 0);
    check("R6 sf count off 104", d_sf_n, 1);
    run(5, 0, 105, 0, 0);
    check("R6 sf count off 105", d_sf_n, 1);
    run(17, 0, 139, 0, 0);
    check("R6 sf count off 139", d_sf_n, 1);
    run(9, 0, 140, 0, 0);
    check("R7 sf count off 140", d_sf_n, 0);
    run(30, 1, 44, 0, 0);
    check("R5 sf count off 300", d_sf_n, 0);
    check("R5 valid bytes off 300", d_vld_n, 194);
    run(0, 0, 0, 0, 0);
    check("R8 valid bytes chan 0", d_vld_n, 0);
    check("R8 sf count chan 0", d_sf_n, 0);
    run(45, 0, 20, 1, 0);
    check("R2 valid bytes with payload gaps", d_vld_n, m_vld_n);
    check("R2 sf count with payload gaps", d_sf_n, m_sf_n);
    run(12, 0, 0, 0, 1);
    check("R9 sf count after resync", d_sf_n, 3);
    check("R9 valid bytes after resync", d_vld_n, m_vld_n);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule